// File: doc/BRIEF.md
# Armed Edge/Level Interrupt Controller

This block collects a vector of interrupt sources and, for each one, applies a set of per-source settings: an arm mask, a choice between edge and level detection, and a polarity. Before any of that logic sees a raw input, the input passes through a hold filter. A new value is accepted only after it has stayed unchanged for a minimum time, set as a number of clock cycles derived from the clock frequency.

An accepted event on an armed source sets that source's pending bit. Software can also set pending bits directly through a request register. A pending bit stays set until the host writes a one to its position in the clear register. While the bit is set, further events on that source add nothing, so only one instance of the interrupt is outstanding at a time. The host interrupt line is raised whenever an enabled source is pending. A bank of routing registers copies the pending state of chosen sources onto external output lines.

Access uses a simple 32-bit word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the registered state.

Top module: `armed_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, no source is pending, `irq` is low and every `ext_out` line is low.
- R2: A change on `src_in[i]` reaches the detection logic only after the input has been sampled at the same value on HOLD+1 consecutive clock edges, where HOLD = ceil(CLK_MHZ*HOLD_NS/1000) and is at least 1. A shorter pulse is ignored.
- R3: With bit i of the mode register (word 4) at 0, source i is edge-triggered. It becomes pending on an inactive-to-active change of its filtered input. Polarity register (word 5) bit i = 0 makes high the active level; bit i = 1 makes low the active level.
- R4: With mode bit i at 1, source i is level-triggered. It is set pending on every cycle its filtered input is active, so a clear written while the input is still active leaves the bit set.
- R5: A source whose bit in the arm register (word 3) is 0 never becomes pending, whether from an input event or from a software request.
- R6: A pending bit (read at word 7) holds until a write to the clear register (word 8) with a one in that position. Events arriving while it is set add nothing. After a clear, an edge-triggered source needs a new edge before it becomes pending again. Bits written as zero to the clear register are left unchanged.
- R7: Writing the request register (word 6) sets the pending bit of every armed source whose bit is written as one, in the cycle after the write.
- R8: `irq` is high exactly when at least one source is both pending and set in the enable register (word 0).
- R9: A write to the enable-set register (word 1) turns on only the enable bits written as one. A write to the enable-clear register (word 2) turns off only the enable bits written as one. All other enable bits keep their values.
- R10: Routing register k (word 16+k) holds a source index in bits [SEL_W-1:0] and an enable in bit 8. `ext_out[k]` equals the pending bit of the selected source when the enable is 1, and is 0 otherwise.
- R11: Words 1, 2, 6, 8 and all unmapped words read as zero. Writes to the pending word (7) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NSRC | Raw interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Host interrupt request |
| ext_out | output | NOUT | Routed external output lines |

## Verification
The assertions assume that `src_in` is synchronous to `clk`. The stimulus therefore changes the sources only on the falling clock edge. The assertions also assume that at most one register write lands per cycle, and the stimulus holds `wr_en` for exactly one cycle per access. Input pulses are deliberately chosen on either side of the hold time: half of it to show rejection, and half again beyond it to show acceptance. Together with the reference model, which is compared on every edge, this exercises the polarity-flip edge, the level-clear race, and requests to unarmed sources.

// File: rtl/airq_pkg.sv
package airq_pkg;
    localparam int AW           = 5;
    localparam int DW           = 32;
    localparam int ROUTE_EN_BIT = 8;

    localparam logic [AW-1:0] A_EN    = 5'd0;
    localparam logic [AW-1:0] A_ENSET = 5'd1;
    localparam logic [AW-1:0] A_ENCLR = 5'd2;
    localparam logic [AW-1:0] A_ARM   = 5'd3;
    localparam logic [AW-1:0] A_LVL   = 5'd4;
    localparam logic [AW-1:0] A_POL   = 5'd5;
    localparam logic [AW-1:0] A_SWREQ = 5'd6;
    localparam logic [AW-1:0] A_PEND  = 5'd7;
    localparam logic [AW-1:0] A_CLR   = 5'd8;
    localparam int            A_ROUTE = 16;
endpackage

// File: rtl/airq_qualify.sv
module airq_qualify #(
    parameter int N    = 32,
    parameter int HOLD = 100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] qual_o
);
    localparam int CW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [N-1:0]         smp;
        logic [N-1:0]         cand;
        logic [N-1:0]         qual;
        logic [N-1:0][CW-1:0] cnt;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d     = q;
        d.smp = raw_i;
        for (int i = 0; i < N; i++) begin
            if (q.smp[i] != q.cand[i]) begin
                d.cand[i] = q.smp[i];
                d.cnt[i]  = '0;
            end else if (q.cnt[i] != CW'(HOLD - 1)) begin
                d.cnt[i] = q.cnt[i] + 1'b1;
            end else begin
                d.qual[i] = q.cand[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign qual_o = q.qual;

    // R2: a filtered bit can only move to the value that was sampled just before
    p_hold_filter_r2: assert property (@(posedge clk) disable iff (rst)
        ((q.qual ^ $past(q.qual)) & (q.qual ^ $past(q.smp))) == '0);
endmodule

// File: rtl/airq_pend.sv
module airq_pend #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] qual_i,
    input  logic [N-1:0] arm_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] swreq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] prevx;
    } pnd_t;

    pnd_t d, q;
    logic [N-1:0] act, evt;

    always_comb begin
        act     = qual_i ^ pol_i;
        evt     = (lvl_i & act) | (~lvl_i & act & ~q.prevx);
        d.prevx = act;
        d.pend  = (q.pend & ~clr_i) | ((evt | swreq_i) & arm_i);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pend_o = q.pend;

    // R5: a newly set pending bit had its arm bit set in the cycle before
    p_unarmed_r5: assert property (@(posedge clk) disable iff (rst)
        (q.pend & ~$past(q.pend) & ~$past(arm_i)) == '0);
    // R6: a pending bit only falls when its clear bit was written
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(q.pend) & ~q.pend & ~$past(clr_i)) == '0);
    // R7: an armed software request is pending one cycle later
    p_swreq_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(swreq_i & arm_i) & ~q.pend) == '0);
endmodule

// File: rtl/airq_route.sv
module airq_route #(
    parameter int NSRC  = 32,
    parameter int NOUT  = 12,
    parameter int SEL_W = 5
) (
    input  logic [NSRC-1:0]            pend_i,
    input  logic [NOUT-1:0][SEL_W-1:0] sel_i,
    input  logic [NOUT-1:0]            en_i,
    output logic [NOUT-1:0]            out_o
);
    for (genvar k = 0; k < NOUT; k++) begin : g_line
        assign out_o[k] = en_i[k] && (32'(sel_i[k]) < NSRC) && pend_i[sel_i[k]];
    end
endmodule

// File: rtl/armed_irq_ctrl.sv
module armed_irq_ctrl
    import airq_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int NOUT    = 12,
    parameter int CLK_MHZ = 100,
    parameter int HOLD_NS = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq,
    output logic [NOUT-1:0] ext_out
);
    localparam int HOLD_RAW = (CLK_MHZ * HOLD_NS + 999) / 1000;
    localparam int HOLD     = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
    localparam int SEL_W    = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]            en;
        logic [NSRC-1:0]            arm;
        logic [NSRC-1:0]            lvl;
        logic [NSRC-1:0]            pol;
        logic [NOUT-1:0][SEL_W-1:0] rsel;
        logic [NOUT-1:0]            ren;
    } regs_t;

    regs_t d, q;
    logic [NSRC-1:0] sw_req, clr_req, qual, pend;

    always_comb begin
        d       = q;
        sw_req  = '0;
        clr_req = '0;
        if (wr_en) begin
            case (wr_addr)
                A_EN:    d.en    = wr_data[NSRC-1:0];
                A_ENSET: d.en    = q.en | wr_data[NSRC-1:0];
                A_ENCLR: d.en    = q.en & ~wr_data[NSRC-1:0];
                A_ARM:   d.arm   = wr_data[NSRC-1:0];
                A_LVL:   d.lvl   = wr_data[NSRC-1:0];
                A_POL:   d.pol   = wr_data[NSRC-1:0];
                A_SWREQ: sw_req  = wr_data[NSRC-1:0];
                A_CLR:   clr_req = wr_data[NSRC-1:0];
                default: ;
            endcase
            for (int k = 0; k < NOUT; k++) begin
                if (wr_addr == AW'(A_ROUTE + k)) begin
                    d.rsel[k] = wr_data[SEL_W-1:0];
                    d.ren[k]  = wr_data[ROUTE_EN_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EN:    rd_data[NSRC-1:0] = q.en;
            A_ARM:   rd_data[NSRC-1:0] = q.arm;
            A_LVL:   rd_data[NSRC-1:0] = q.lvl;
            A_POL:   rd_data[NSRC-1:0] = q.pol;
            A_PEND:  rd_data[NSRC-1:0] = pend;
            default: ;
        endcase
        for (int k = 0; k < NOUT; k++) begin
            if (rd_addr == AW'(A_ROUTE + k)) begin
                rd_data[SEL_W-1:0]   = q.rsel[k];
                rd_data[ROUTE_EN_BIT] = q.ren[k];
            end
        end
    end

    airq_qualify #(.N(NSRC), .HOLD(HOLD)) u_qual (
        .clk(clk), .rst(rst), .raw_i(src_in), .qual_o(qual)
    );

    airq_pend #(.N(NSRC)) u_pend (
        .clk(clk), .rst(rst), .qual_i(qual), .arm_i(q.arm), .lvl_i(q.lvl),
        .pol_i(q.pol), .swreq_i(sw_req), .clr_i(clr_req), .pend_o(pend)
    );

    airq_route #(.NSRC(NSRC), .NOUT(NOUT), .SEL_W(SEL_W)) u_route (
        .pend_i(pend), .sel_i(q.rsel), .en_i(q.ren), .out_o(ext_out)
    );

    assign irq = |(pend & q.en);

    // R9: enable-set turns on the written ones and leaves the rest alone
    p_enset_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_ENSET) |=>
        (((q.en ^ $past(q.en)) & ~$past(wr_data[NSRC-1:0])) == '0) &&
        ((q.en & $past(wr_data[NSRC-1:0])) == $past(wr_data[NSRC-1:0])));
    // R9: enable-clear turns off the written ones and leaves the rest alone
    p_enclr_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_ENCLR) |=>
        (((q.en ^ $past(q.en)) & ~$past(wr_data[NSRC-1:0])) == '0) &&
        ((q.en & $past(wr_data[NSRC-1:0])) == '0));
    // R10: a disabled route line stays low
    p_route_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (ext_out & ~q.ren) == '0);
endmodule

// File: tb/tb_armed_irq_ctrl.sv
module tb_armed_irq_ctrl;
    import airq_pkg::*;

    localparam time CLK_PERIOD = 10;
    localparam int  NS   = 32;
    localparam int  NO   = 12;
    localparam int  HOLD = 100;
    localparam int  SW   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = A_PEND;
    logic [DW-1:0] rd_data;
    logic          irq;
    logic [NO-1:0] ext_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    armed_irq_ctrl #(.NSRC(NS), .NOUT(NO), .CLK_MHZ(100), .HOLD_NS(1000)) dut (
        .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .ext_out(ext_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state
    logic [NS-1:0] m_en, m_arm, m_lvl, m_pol, m_pend, m_prev, m_qual, m_last;
    int            m_run [NS];
    logic [SW-1:0] m_sel [NO];
    logic          m_ren [NO];

    function automatic logic [DW-1:0] mread(input logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            A_EN:   r = m_en;
            A_ARM:  r = m_arm;
            A_LVL:  r = m_lvl;
            A_POL:  r = m_pol;
            A_PEND: r = m_pend;
            default: ;
        endcase
        for (int k = 0; k < NO; k++)
            if (int'(a) == A_ROUTE + k) begin
                r = '0;
                r[SW-1:0] = m_sel[k];
                r[ROUTE_EN_BIT] = m_ren[k];
            end
        return r;
    endfunction

    function automatic logic [NO-1:0] mext();
        logic [NO-1:0] e = '0;
        for (int k = 0; k < NO; k++) e[k] = m_ren[k] & m_pend[m_sel[k]];
        return e;
    endfunction

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_en = '0; m_arm = '0; m_lvl = '0; m_pol = '0; m_pend = '0;
            m_prev = '0; m_qual = '0; m_last = '0;
            for (int i = 0; i < NS; i++) m_run[i] = 0;
            for (int k = 0; k < NO; k++) begin m_sel[k] = '0; m_ren[k] = 1'b0; end
        end else begin
            logic [NS-1:0] act, evt, sw, clr;
            check(DW'(irq), DW'(|(m_pend & m_en)), "R8 irq per cycle");
            check(DW'(ext_out), DW'(mext()), "R10 ext_out per cycle");
            check(rd_data, mread(rd_addr), "R11 read per cycle");
            sw = '0; clr = '0;
            if (wr_en) begin
                if (wr_addr == A_SWREQ) sw  = wr_data[NS-1:0];
                if (wr_addr == A_CLR)   clr = wr_data[NS-1:0];
            end
            act = m_qual ^ m_pol;
            for (int i = 0; i < NS; i++)
                evt[i] = m_lvl[i] ? act[i] : (act[i] && !m_prev[i]);
            m_pend = (m_pend & ~clr) | ((evt | sw) & m_arm);
            m_prev = act;
            for (int i = 0; i < NS; i++) begin
                if (m_run[i] >= HOLD + 1) m_qual[i] = m_last[i];
                if (src_in[i] == m_last[i]) m_run[i]++;
                else begin m_last[i] = src_in[i]; m_run[i] = 1; end
            end
            if (wr_en) begin
                case (wr_addr)
                    A_EN:    m_en  = wr_data;
                    A_ENSET: m_en  = m_en | wr_data;
                    A_ENCLR: m_en  = m_en & ~wr_data;
                    A_ARM:   m_arm = wr_data;
                    A_LVL:   m_lvl = wr_data;
                    A_POL:   m_pol = wr_data;
                    default: ;
                endcase
                for (int k = 0; k < NO; k++)
                    if (int'(wr_addr) == A_ROUTE + k) begin
                        m_sel[k] = wr_data[SW-1:0];
                        m_ren[k] = wr_data[ROUTE_EN_BIT];
                    end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1 check(rd_data, exp, tag);
        rd_addr = A_PEND;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        // R1: reset state
        chk_rd(A_EN, 0, "R1 enable after reset");
        chk_rd(A_ARM, 0, "R1 arm after reset");
        chk_rd(A_PEND, 0, "R1 pending after reset");
        chk_rd(A_ROUTE, 0, "R1 route after reset");
        check(DW'(irq), 0, "R1 irq after reset");
        check(DW'(ext_out), 0, "R1 ext_out after reset");
        // R11: pending is read-only
        wr(A_PEND, 32'hFFFF_FFFF);
        chk_rd(A_PEND, 0, "R11 write to pending ignored");
        // R5: unarmed input event
        src_in[4] = 1'b1;
        wait_cyc(150);
        chk_rd(A_PEND, 0, "R5 unarmed source not pending");
        src_in[4] = 1'b0;
        wr(A_ARM, 32'h0000_00FF);
        // R9: enable set/clear
        wr(A_ENSET, 32'h3);
        chk_rd(A_EN, 32'h3, "R9 enable set");
        wr(A_ENCLR, 32'h1);
        chk_rd(A_EN, 32'h2, "R9 enable clear keeps other bits");
        wr(A_ENSET, 32'h1);
        chk_rd(A_EN, 32'h3, "R9 enable set keeps other bits");
        wait_cyc(150);
        // R2: short pulse rejected
        src_in[0] = 1'b1;
        wait_cyc(50);
        src_in[0] = 1'b0;
        wait_cyc(150);
        chk_rd(A_PEND, 0, "R2 short pulse ignored");
        // R3: rising edge accepted after hold
        src_in[0] = 1'b1;
        wait_cyc(110);
        chk_rd(A_PEND, 32'h1, "R3 rising edge pending");
        check(DW'(irq), 1, "R8 irq with enabled pending");
        // R6: second edge while pending adds nothing, clear releases
        src_in[0] = 1'b0;
        wait_cyc(150);
        src_in[0] = 1'b1;
        wait_cyc(150);
        chk_rd(A_PEND, 32'h1, "R6 still single pending");
        wr(A_CLR, 32'h1);
        chk_rd(A_PEND, 0, "R6 clear removes pending");
        check(DW'(irq), 0, "R8 irq low after clear");
        wait_cyc(150);
        chk_rd(A_PEND, 0, "R6 no new instance without edge");
        // R3: active-low polarity on source 1
        wr(A_POL, 32'h2);
        wr(A_CLR, 32'h2);
        src_in[1] = 1'b1;
        wait_cyc(150);
        chk_rd(A_PEND, 0, "R3 inactive move under low polarity");
        src_in[1] = 1'b0;
        wait_cyc(150);
        chk_rd(A_PEND, 32'h2, "R3 falling edge with low polarity");
        wr(A_CLR, 32'h2);
        // R4: level mode on source 2
        wr(A_LVL, 32'h4);
        src_in[2] = 1'b1;
        wait_cyc(150);
        chk_rd(A_PEND, 32'h4, "R4 level pending");
        wr(A_CLR, 32'h4);
        chk_rd(A_PEND, 32'h4, "R4 clear while level active");
        src_in[2] = 1'b0;
        wait_cyc(150);
        wr(A_CLR, 32'h4);
        chk_rd(A_PEND, 0, "R4 clear after level drops");
        // R7: software request, bit 8 unarmed
        wr(A_SWREQ, 32'h0000_0108);
        chk_rd(A_PEND, 32'h8, "R7 software request armed only");
        check(DW'(irq), 0, "R8 irq low for unenabled pending");
        chk_rd(A_SWREQ, 0, "R11 request word reads zero");
        wr(A_CLR, 32'hFFFF_FFFF);
        // R10: routing
        wr(AW'(A_ROUTE), 32'h103);
        wr(AW'(A_ROUTE + 11), 32'h105);
        wr(AW'(A_ROUTE + 5), 32'h005);
        chk_rd(AW'(A_ROUTE), 32'h103, "R10 route readback");
        wr(A_SWREQ, 32'h8);
        #1 check(DW'(ext_out), 12'h001, "R10 route line 0");
        wr(A_SWREQ, 32'h20);
        #1 check(DW'(ext_out), 12'h801, "R10 route line 11, line 5 disabled");
        wr(A_CLR, 32'hFFFF_FFFF);
        #1 check(DW'(ext_out), 0, "R10 lines drop after clear");
        wait_cyc(5);
        done = 1;
        finish_run();
    end
endmodule